// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers up to 128 level-sensitive interrupt lines, split into banks of 32. It presents one of them at a time to a processor on a single interrupt output. Each bank has its own mask. Software changes the mask through two write-one addresses: one sets mask bits and one clears them. A per-bank pending view shows the raw line levels with the masked lines removed.

When nothing is being serviced, the controller captures the lowest-numbered pending, unmasked line. It holds that line's number in the active-number register and raises the interrupt output. The captured number stays fixed until software writes an acknowledge. The acknowledge always releases the capture, even if the line has since been masked or has dropped. This keeps the controller from stalling.

A configuration register carries an autoidle enable and a soft-reset trigger. The soft reset runs for a fixed number of cycles, and a status flag reports when it has finished. A revision register identifies the block. The register port is a plain single-cycle interface: writes take effect at the clock edge and reads return data combinationally in the same cycle.

Top module: `irq_hub`

## Requirements
- R1: After reset, every mask register reads 0xFFFFFFFF, the active-number register (0x40) reads 0, `irq_out` is low, and bit 0 of the status register (0x14) reads 1.
- R2: Writing 1s to a bank's mask-clear address (bank 0: 0x88) clears those mask bits. Writing 1s to its mask-set address (bank 0: 0x8C) sets them. Bits written as 0 keep their value. The mask register (bank 0: 0x84) reads back the current mask, where 1 means masked.
- R3: A bank's pending register (bank 0: 0x98) reads as line level AND NOT mask, one bit per line.
- R4: Line n belongs to bank n/32 at bit n%32. The registers of bank b sit at the bank-0 offsets plus 0x20*b. The line count is 96 or 128.
- R5: When no line is active and at least one line is pending, the next clock edge captures the lowest-numbered pending line and raises `irq_out`. The captured number reads in bits [6:0] of 0x40.
- R6: Until an acknowledge is written, the captured number and `irq_out` stay unchanged, even if lines drop, are masked, or lower-numbered lines become pending.
- R7: Writing 1 to bit 0 of the control register (0x48) releases the active line at that edge, even if that line is no longer pending. `irq_out` is then low and 0x40 reads 0 for one cycle. The next pending line is captured at the following edge.
- R8: Bit 0 of the configuration register (0x10) is a read/write autoidle enable.
- R9: Writing 1 to bit 1 of 0x10 starts a soft reset. Status bit 0 then reads 0 for RESET_CYCLES cycles and afterwards reads 1. All registers return to their R1 values, autoidle returns to 0, and bit 1 of 0x10 always reads 0.
- R10: The revision register (0x00) reads the major version in bits [7:4] and the minor version in bits [3:0]. Bits [31:8] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | NUM_SRC | Interrupt line levels, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the access |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Mask, pending and register reads are combinational. The bench therefore samples them 1 ns after driving the address, with no clock edge in between. A capture happens one edge after a line becomes pending under the updated mask, so the bench waits one falling edge after the write or level change before reading 0x40 and `irq_out`. After an acknowledge, the bench checks for the idle value at the falling edge that ends the write. It checks for the next capture one cycle after that. The soft-reset flag is read immediately after the trigger, three cycles later (still 0), and at the fourth cycle (1). This places the checks exactly at the boundaries of the RESET_CYCLES window.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
   localparam int unsigned BANK_W       = 32;
   localparam int unsigned BANK_STRIDE  = 32'h20;
   localparam int unsigned OFS_REV      = 32'h000;
   localparam int unsigned OFS_CFG      = 32'h010;
   localparam int unsigned OFS_STAT     = 32'h014;
   localparam int unsigned OFS_ACTIVE   = 32'h040;
   localparam int unsigned OFS_CTRL     = 32'h048;
   localparam int unsigned OFS_MASK     = 32'h084;
   localparam int unsigned OFS_MCLR     = 32'h088;
   localparam int unsigned OFS_MSET     = 32'h08C;
   localparam int unsigned OFS_PEND     = 32'h098;
   localparam int unsigned CFG_IDLE_BIT = 0;
   localparam int unsigned CFG_SRST_BIT = 1;
endpackage

// File: rtl/irq_hub_bank.sv
module irq_hub_bank #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] mask_q,
   output logic [W-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mask_q <= '1;
      else if (soft_clr) mask_q <= '1;
      else if (set_we)   mask_q <= mask_q | wdata;
      else if (clr_we)   mask_q <= mask_q & ~wdata;
   end

   assign pend = lvl & ~mask_q;

   // R2: write-one set masks the selected lines
   a_r2_set_masks: assert property (@(posedge clk) disable iff (!rst_n)
      set_we && !soft_clr |=> ((mask_q & $past(wdata)) == $past(wdata)));
   // R2: write-one clear unmasks the selected lines
   a_r2_clr_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we && !set_we && !soft_clr |=> ((mask_q & $past(wdata)) == '0));
   // R2: positions written as zero are left alone
   a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we || clr_we) && !soft_clr |=>
         (((mask_q ^ $past(mask_q)) & ~$past(wdata)) == '0));
   // R9: a soft reset leaves every line masked
   a_r9_mask_restored: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (mask_q == '1));
endmodule

// File: rtl/irq_hub_pick.sv
module irq_hub_pick #(
   parameter int unsigned N  = 96,
   parameter int unsigned IW = 7
) (
   input  logic [N-1:0]  pend,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) idx = IW'(i);
      end
   end

   assign hit = |pend;
endmodule

// File: rtl/irq_hub_srst.sv
module irq_hub_srst #(
   parameter int unsigned CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("irq_hub_srst: CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (start && cnt_q == '0)  cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R9: a trigger while idle opens the busy window
   a_r9_busy_starts: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy);
   // R9: the window ends after the last count
   a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cnt_q == CW'(1) |=> !busy);
endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 96,
   parameter int unsigned AW         = 12,
   parameter int unsigned RST_CYCLES = 4,
   parameter int unsigned REV_MAJOR  = 2,
   parameter int unsigned REV_MINOR  = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [AW-1:0]      bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_out
);
   localparam int unsigned NB = NUM_SRC / BANK_W;
   localparam int unsigned IW = $clog2(NUM_SRC);

   if (!(NUM_SRC == 96 || NUM_SRC == 128)) begin : g_bad_num
      $error("irq_hub: NUM_SRC must be 96 or 128");
   end
   if (AW < 8) begin : g_bad_aw
      $error("irq_hub: AW too narrow for the register map");
   end
   if (REV_MAJOR > 15 || REV_MINOR > 15) begin : g_bad_rev
      $error("irq_hub: revision fields are 4 bits");
   end

   logic              busy;
   logic              wr_ok;
   logic              cfg_we, ack_we, srst_go;
   logic              autoidle_q;
   logic              act_valid_q;
   logic [IW-1:0]     act_num_q;
   logic              pick_hit;
   logic [IW-1:0]     pick_idx;
   logic [NUM_SRC-1:0] pend_all;
   logic [NB-1:0][BANK_W-1:0] mask_all;
   logic [NB-1:0][BANK_W-1:0] pend_bank;

   assign wr_ok   = bus_sel && bus_wr && !busy;
   assign cfg_we  = wr_ok && (bus_addr == AW'(OFS_CFG));
   assign ack_we  = wr_ok && (bus_addr == AW'(OFS_CTRL)) && bus_wdata[0];
   assign srst_go = cfg_we && bus_wdata[CFG_SRST_BIT];

   irq_hub_srst #(.CYCLES(RST_CYCLES)) u_srst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (srst_go),
      .busy  (busy)
   );

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic set_we, clr_we;
      assign set_we = wr_ok && (bus_addr == AW'(OFS_MSET + b * BANK_STRIDE));
      assign clr_we = wr_ok && (bus_addr == AW'(OFS_MCLR + b * BANK_STRIDE));

      irq_hub_bank #(.W(BANK_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_clr (busy),
         .set_we   (set_we),
         .clr_we   (clr_we),
         .wdata    (bus_wdata),
         .lvl      (src_lvl[b*BANK_W +: BANK_W]),
         .mask_q   (mask_all[b]),
         .pend     (pend_bank[b])
      );
      assign pend_all[b*BANK_W +: BANK_W] = pend_bank[b];
   end

   irq_hub_pick #(.N(NUM_SRC), .IW(IW)) u_pick (
      .pend (pend_all),
      .hit  (pick_hit),
      .idx  (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         autoidle_q <= 1'b0;
      end else if (busy) begin
         autoidle_q <= 1'b0;
      end else if (cfg_we) begin
         autoidle_q <= bus_wdata[CFG_IDLE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid_q <= 1'b0;
         act_num_q   <= '0;
      end else if (busy || ack_we) begin
         act_valid_q <= 1'b0;
         act_num_q   <= '0;
      end else if (!act_valid_q && pick_hit) begin
         act_valid_q <= 1'b1;
         act_num_q   <= pick_idx;
      end
   end

   assign irq_out = act_valid_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == AW'(OFS_REV))
            bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
         if (bus_addr == AW'(OFS_CFG))
            bus_rdata = {31'd0, autoidle_q};
         if (bus_addr == AW'(OFS_STAT))
            bus_rdata = {31'd0, !busy};
         if (bus_addr == AW'(OFS_ACTIVE))
            bus_rdata = 32'(act_num_q);
         for (int b = 0; b < NB; b++) begin
            if (bus_addr == AW'(OFS_MASK + b * BANK_STRIDE)) bus_rdata = mask_all[b];
            if (bus_addr == AW'(OFS_PEND + b * BANK_STRIDE)) bus_rdata = pend_bank[b];
         end
      end
   end

   // R5: the picker only names a pending line
   a_r5_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pick_hit |-> pend_all[pick_idx]);
   // R5: an idle controller with a pending line raises the output
   a_r5_present: assert property (@(posedge clk) disable iff (!rst_n)
      !act_valid_q && pick_hit && !ack_we && !busy |=> irq_out);
   // R6: the captured number holds until acknowledge
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out && !ack_we && !busy |=> irq_out && $stable(act_num_q));
   // R7: an acknowledge always drops the output
   a_r7_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> !irq_out);
   // R9: the soft reset leaves nothing active
   a_r9_no_active: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !irq_out && act_num_q == '0);
endmodule

// File: tb/irq_hub_bench.sv
`timescale 1ns/1ps
module irq_hub_bench;
   localparam int NUM_SRC = 96;
   localparam int AW = 12;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_SRC-1:0] src_lvl = '0;
   logic               bus_sel = 1'b0;
   logic               bus_wr = 1'b0;
   logic [AW-1:0]      bus_addr = '0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic               irq_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_hub #(.NUM_SRC(NUM_SRC), .AW(AW), .RST_CYCLES(4),
             .REV_MAJOR(2), .REV_MINOR(1)) u_irq_hub (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_lvl   (src_lvl),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [31:0] v;
      rd(12'h084, v); chk("R1 mask0 after reset", v, 32'hFFFF_FFFF);
      rd(12'h0C4, v); chk("R1 mask2 after reset", v, 32'hFFFF_FFFF);
      rd(12'h040, v); chk("R1 active after reset", v, 32'h0);
      rd(12'h014, v); chk("R1 status after reset", v, 32'h1);
      chk("R1 irq_out after reset", 32'(irq_out), 32'h0);
      rd(12'h000, v); chk("R10 revision", v, 32'h0000_0021);
   endtask

   task automatic t_mask_ops();
      logic [31:0] v;
      wr(12'h088, 32'h0000_00F0);
      rd(12'h084, v); chk("R2 mask-clear", v, 32'hFFFF_FF0F);
      wr(12'h08C, 32'h0000_0010);
      rd(12'h084, v); chk("R2 mask-set", v, 32'hFFFF_FF1F);
   endtask

   task automatic t_pending_and_capture();
      logic [31:0] v;
      src_lvl[4] = 1'b1; src_lvl[5] = 1'b1;
      rd(12'h098, v); chk("R3 pending = level and not mask", v, 32'h0000_0020);
      idle(1);
      chk("R5 irq_out raised", 32'(irq_out), 32'h1);
      rd(12'h040, v); chk("R5 captured number", v, 32'd5);
      src_lvl[2] = 1'b1;
      wr(12'h088, 32'h0000_0004);
      idle(1);
      rd(12'h040, v); chk("R6 held despite lower pending", v, 32'd5);
      chk("R6 irq_out held", 32'(irq_out), 32'h1);
      wr(12'h048, 32'h1);
      chk("R7 irq_out low after ack", 32'(irq_out), 32'h0);
      rd(12'h040, v); chk("R7 active idle after ack", v, 32'h0);
      idle(1);
      rd(12'h040, v); chk("R7 next capture is lowest", v, 32'd2);
   endtask

   task automatic t_stale_ack();
      logic [31:0] v;
      src_lvl[2] = 1'b0;
      idle(1);
      rd(12'h040, v); chk("R6 held after line dropped", v, 32'd2);
      wr(12'h048, 32'h1);
      idle(1);
      rd(12'h040, v); chk("R7 ack of dropped line moves on", v, 32'd5);
      wr(12'h08C, 32'h0000_0020);
      chk("R6 irq_out held after masking", 32'(irq_out), 32'h1);
      wr(12'h048, 32'h1);
      idle(1);
      rd(12'h040, v); chk("R7 ack of masked line releases", v, 32'h0);
      chk("R7 irq_out low with nothing pending", 32'(irq_out), 32'h0);
   endtask

   task automatic t_upper_bank();
      logic [31:0] v;
      src_lvl[70] = 1'b1;
      wr(12'h0C8, 32'h0000_0040);
      rd(12'h0C4, v); chk("R4 bank2 mask", v, 32'hFFFF_FFBF);
      rd(12'h0D8, v); chk("R4 bank2 pending", v, 32'h0000_0040);
      idle(1);
      rd(12'h040, v); chk("R4 line 70 captured", v, 32'd70);
      wr(12'h0CC, 32'h0000_0040);
      wr(12'h048, 32'h1);
      idle(1);
      rd(12'h040, v); chk("R7 released after bank2 mask", v, 32'h0);
   endtask

   task automatic t_autoidle();
      logic [31:0] v;
      wr(12'h010, 32'h1);
      rd(12'h010, v); chk("R8 autoidle set", v, 32'h1);
      wr(12'h010, 32'h0);
      rd(12'h010, v); chk("R8 autoidle cleared", v, 32'h0);
      wr(12'h010, 32'h1);
   endtask

   task automatic t_soft_reset();
      logic [31:0] v;
      wr(12'h088, 32'h0000_0020);
      idle(1);
      rd(12'h040, v); chk("R5 line 5 active before soft reset", v, 32'd5);
      wr(12'h010, 32'h2);
      rd(12'h014, v); chk("R9 status low at start", v, 32'h0);
      idle(3);
      rd(12'h014, v); chk("R9 status low at last busy cycle", v, 32'h0);
      idle(1);
      rd(12'h014, v); chk("R9 status high when done", v, 32'h1);
      rd(12'h010, v); chk("R9 config cleared, bit1 reads 0", v, 32'h0);
      rd(12'h084, v); chk("R9 mask0 restored", v, 32'hFFFF_FFFF);
      rd(12'h098, v); chk("R9 pending0 after restore", v, 32'h0);
      rd(12'h040, v); chk("R9 active cleared", v, 32'h0);
      chk("R9 irq_out low", 32'(irq_out), 32'h0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset_state();
      t_mask_ops();
      t_pending_and_capture();
      t_stale_ack();
      t_upper_bank();
      t_autoidle();
      t_soft_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule